// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash transaction each time software writes its launch bit. Software first loads a set of 32-bit configuration registers through a simple write/read port: the frame selector with its opcode and line-width bits, the extended frame shape, the flash address, the data word, the timing word and the address-size word. It then sets the launch bit and polls that same bit. The bit reads back as 1 until the transaction is over.

On the flash side the block drives an active-low chip select, a serial clock that idles low, and four data lines, each with its own output enable. A frame is always an opcode, optionally followed by address bytes, dummy clocks and up to four data bytes. The data bytes are either written from the data register or read into it. Only the data bytes can be carried on two or four lines; the opcode and address always use one line.

Register index on `reg_waddr`/`reg_raddr`: 0 launch, 1 frame select, 2 extended shape, 3 address, 4 data, 5 timing, 6 address size.

Top module: `sfl_cmd_engine`

## Requirements
- R1: After reset all seven registers read 0, chip select is high, the serial clock is low and every output enable is 0.
- R2: Writing 1 to bit 1 of the launch register (index 0) starts a frame. Bit 1 then reads 1 from the next cycle until the idle guard after the frame ends, and it returns to 0 on its own. A launch write made while bit 1 is set is ignored.
- R3: With frame code 0 (bits 11:8 of index 1), the frame is the opcode from bits 7:0 of index 1 only. It is sent most significant bit first on line 0, one bit per serial clock.
- R4: With frame code 5, the opcode is followed by address bytes from index 3, most significant byte first. Four bytes are sent when bits 10:9 of index 6 equal 2, and three bytes otherwise.
- R5: With frame code 15 and bit 31 of index 2 set, the shape comes from index 2. The opcode is bits 7:0. The address byte count is bits 23:21 plus one, capped at 5; a fifth byte goes out as 0 ahead of the 32-bit address. Next come bits 29:24 plus one dummy clocks, with all lines released. The data byte count is bits 20:8 plus one, capped at 4.
- R6: A launch with any other frame code, or with code 15 while bit 31 of index 2 is clear, produces no chip-select activity. Bit 1 still reads 1 for the idle-guard time.
- R7: Setting bit 9 together with bit 1 of the launch register makes the data phase a write. The bytes of index 4 are sent in the order bits 7:0, 15:8, 23:16, 31:24, each most significant bit first, with the used lines enabled. Index 4 is left unchanged.
- R8: Without bit 9, the data phase reads with all lines released. The first byte received lands in bits 7:0 of index 4, the next in 15:8, and so on. Bytes not received read as 0, and index 4 is updated before bit 1 clears.
- R9: When bit 24 of index 1 is set, bits 31:30 select the data-phase width: 1 is two lines, each clock carrying byte bits 7:6, then 5:4, and so on on lines 1:0; 2 is four lines, carrying 7:4 then 3:0 on lines 3:0. Any other case uses one line, which is line 0 out and line 1 in.
- R10: The timing register (index 5) sets the serial clock. Each clock has a low half and a high half of (bits 26:24 + 1) system cycles each. Chip select goes low for max(bits 23:16, 1) cycles before the first low half, stays low for max(bits 15:8, 1) cycles after the last high half, and then stays high for max(bits 7:0, 1) cycles before the block accepts another launch.
- R11: Writes to indices 1 to 6 are ignored while bit 1 of index 0 reads 1.
- R12: The serial clock is low whenever chip select is high. Output data changes only where the clock falls or inside the setup time, and input lines are captured where the clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register index for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock |
| fl_dq_out | output | 4 | Data lines driven toward the flash |
| fl_dq_oe | output | 4 | Per-line output enable |
| fl_dq_in | input | 4 | Data lines sampled from the flash |

## Verification
A wrong segment or beat count shows up as a surplus or missing serial clock edge. It appears at the ports in the very cycle the clock half that follows is due, well before the busy bit would give it away. A wrong shift amount or lane choice corrupts the line values within one clock of the affected byte. A wrong read assembly is only visible in the data register once the frame ends. The bench therefore predicts chip select, clock, enables, output lines and the busy bit for every system cycle of every frame, and reads the data register back after each read.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;
  localparam int REG_AW = 3;
  localparam int WORD_W = 32;
  localparam int TX_W   = 40;

  typedef enum logic [2:0] {
    RI_START = 3'd0, RI_ACCESS = 3'd1, RI_EXT = 3'd2, RI_ADDR = 3'd3,
    RI_DATA  = 3'd4, RI_TIMING = 3'd5, RI_TYPE = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {SEG_OPC, SEG_ADR, SEG_DMY, SEG_DAT} seg_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD, ST_GAP
  } st_e;

  typedef struct packed {
    logic       valid;
    logic [7:0] opc;
    logic [2:0] nadr;
    logic [6:0] ndmy;
    logic [2:0] ndat;
    logic [1:0] lane_log;
  } frame_t;

  // minimum-one count, returned minus one for a down counter
  function automatic logic [7:0] span_m1(logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

  // address bytes left-aligned, most significant first, extra byte zero
  function automatic logic [TX_W-1:0] addr_load(logic [WORD_W-1:0] a, logic [2:0] n);
    logic [TX_W-1:0] full;
    full = {8'h00, a};
    return (n == 3'd0) ? '0 : full << (8 * (5 - int'(n)));
  endfunction

  // data word in stream order: low byte first
  function automatic logic [TX_W-1:0] wdata_load(logic [WORD_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24], 8'h00};
  endfunction

  // received stream (last byte in LSBs) back to little-endian word
  function automatic logic [WORD_W-1:0] rx_to_word(logic [WORD_W-1:0] rx, logic [2:0] n);
    logic [WORD_W-1:0] w;
    logic [WORD_W-1:0] s;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) begin
        s = rx >> (8 * (int'(n) - 1 - i));
        w[8*i +: 8] = s[7:0];
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/sfl_regs.sv
`timescale 1ns/1ps
module sfl_regs import sfl_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   waddr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [REG_AW-1:0]   raddr,
  output logic [WORD_W-1:0]   rdata,
  input  logic                busy,
  input  logic                rx_load,
  input  logic [WORD_W-1:0]   rx_word,
  output logic                start_pulse,
  output logic                write_q,
  output logic [WORD_W-1:0]   acc_q,
  output logic [WORD_W-1:0]   ext_q,
  output logic [WORD_W-1:0]   adr_q,
  output logic [WORD_W-1:0]   dat_q,
  output logic [WORD_W-1:0]   tim_q,
  output logic [WORD_W-1:0]   typ_q
);
  logic cfg_we;
  assign cfg_we      = wr_en && !busy;
  assign start_pulse = cfg_we && (waddr == RI_START) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      acc_q <= '0; ext_q <= '0; adr_q <= '0;
      dat_q <= '0; tim_q <= '0; typ_q <= '0;
    end else begin
      if (cfg_we) begin
        unique case (waddr)
          RI_START:  write_q <= wdata[9];
          RI_ACCESS: acc_q <= wdata;
          RI_EXT:    ext_q <= wdata;
          RI_ADDR:   adr_q <= wdata;
          RI_DATA:   dat_q <= wdata;
          RI_TIMING: tim_q <= wdata;
          RI_TYPE:   typ_q <= wdata;
          default: ;
        endcase
      end
      if (rx_load) dat_q <= rx_word;
    end
  end

  always_comb begin
    unique case (raddr)
      RI_START:  rdata = {22'd0, write_q && busy, 7'd0, busy, 1'b0};
      RI_ACCESS: rdata = acc_q;
      RI_EXT:    rdata = ext_q;
      RI_ADDR:   rdata = adr_q;
      RI_DATA:   rdata = dat_q;
      RI_TIMING: rdata = tim_q;
      RI_TYPE:   rdata = typ_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfl_frame_dec.sv
`timescale 1ns/1ps
module sfl_frame_dec import sfl_pkg::*; (
  input  logic [3:0] code,
  input  logic [7:0] acc_opc,
  input  logic       multi_en,
  input  logic [1:0] width_sel,
  input  logic [1:0] size_sel,
  input  logic       ext_en,
  input  logic [7:0] ext_opc,
  input  logic [2:0] ext_adr_m1,
  input  logic [5:0] ext_dmy_m1,
  input  logic [12:0] ext_dat_m1,
  output frame_t     frm
);
  always_comb begin
    frm = '0;
    unique case (code)
      4'h0: begin
        frm.valid = 1'b1;
        frm.opc   = acc_opc;
      end
      4'h5: begin
        frm.valid = 1'b1;
        frm.opc   = acc_opc;
        frm.nadr  = (size_sel == 2'd2) ? 3'd4 : 3'd3;
      end
      4'hF: begin
        if (ext_en) begin
          frm.valid = 1'b1;
          frm.opc   = ext_opc;
          frm.nadr  = (ext_adr_m1 >= 3'd4) ? 3'd5 : ext_adr_m1 + 3'd1;
          frm.ndmy  = {1'b0, ext_dmy_m1} + 7'd1;
          frm.ndat  = (|ext_dat_m1[12:2]) ? 3'd4 : {1'b0, ext_dat_m1[1:0]} + 3'd1;
          if (multi_en && width_sel == 2'd1)      frm.lane_log = 2'd1;
          else if (multi_en && width_sel == 2'd2) frm.lane_log = 2'd2;
          else                                    frm.lane_log = 2'd0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sfl_shifter.sv
`timescale 1ns/1ps
module sfl_shifter import sfl_pkg::*; #(
  parameter int TCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              write,
  input  frame_t            frm,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [2:0]        div_sel,
  input  logic [7:0]        setup_cyc,
  input  logic [7:0]        hold_cyc,
  input  logic [7:0]        idle_cyc,
  input  logic [3:0]        dq_in,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic              busy,
  output logic              rx_load,
  output logic [WORD_W-1:0] rx_word,
  output logic              sample_evt,
  output logic              launch_evt
);
  localparam int BEAT_W = 7;

  st_e               state;
  seg_e              seg, nxt_seg;
  logic              nxt_has;
  logic [TCNT_W-1:0] cnt;
  logic [BEAT_W-1:0] beats, nxt_beats;
  logic [TX_W-1:0]   tx, nxt_tx;
  logic [WORD_W-1:0] rx;
  logic [1:0]        cur_ll;
  logic [TCNT_W-1:0] half_m1, setup_m1, hold_m1, idle_m1;
  logic              drive, last_beat;
  logic [3:0]        lane_mask, lane_bits;

  assign half_m1  = TCNT_W'(div_sel);
  assign setup_m1 = TCNT_W'(span_m1(setup_cyc));
  assign hold_m1  = TCNT_W'(span_m1(hold_cyc));
  assign idle_m1  = TCNT_W'(span_m1(idle_cyc));

  assign busy       = (state != ST_IDLE);
  assign cs_n       = (state == ST_IDLE) || (state == ST_GAP);
  assign sck        = (state == ST_HIGH);
  assign sample_evt = (state == ST_LOW)  && (cnt == '0);
  assign launch_evt = (state == ST_HIGH) && (cnt == '0);
  assign last_beat  = (beats == BEAT_W'(1));
  assign cur_ll     = (seg == SEG_DAT) ? frm.lane_log : 2'd0;

  // segment order: opcode, address, dummy, data; empty ones skipped
  always_comb begin
    nxt_has = 1'b1;
    nxt_seg = seg;
    unique case (seg)
      SEG_OPC: if (frm.nadr != 3'd0)      nxt_seg = SEG_ADR;
               else if (frm.ndmy != 7'd0) nxt_seg = SEG_DMY;
               else if (frm.ndat != 3'd0) nxt_seg = SEG_DAT;
               else                       nxt_has = 1'b0;
      SEG_ADR: if (frm.ndmy != 7'd0)      nxt_seg = SEG_DMY;
               else if (frm.ndat != 3'd0) nxt_seg = SEG_DAT;
               else                       nxt_has = 1'b0;
      SEG_DMY: if (frm.ndat != 3'd0)      nxt_seg = SEG_DAT;
               else                       nxt_has = 1'b0;
      default: nxt_has = 1'b0;
    endcase
    unique case (nxt_seg)
      SEG_ADR: begin nxt_tx = addr_load(addr, frm.nadr); nxt_beats = {1'b0, frm.nadr, 3'b000}; end
      SEG_DMY: begin nxt_tx = '0; nxt_beats = frm.ndmy; end
      SEG_DAT: begin
        nxt_tx    = write ? wdata_load(wdata) : '0;
        nxt_beats = {1'b0, frm.ndat, 3'b000} >> frm.lane_log;
      end
      default: begin nxt_tx = '0; nxt_beats = BEAT_W'(8); end
    endcase
  end

  always_comb begin
    unique case (cur_ll)
      2'd0:    begin lane_mask = 4'b0001; lane_bits = {3'b000, tx[TX_W-1]}; end
      2'd1:    begin lane_mask = 4'b0011; lane_bits = {2'b00, tx[TX_W-1 -: 2]}; end
      default: begin lane_mask = 4'b1111; lane_bits = tx[TX_W-1 -: 4]; end
    endcase
    drive  = (state == ST_SETUP || state == ST_LOW || state == ST_HIGH) &&
             (seg == SEG_OPC || seg == SEG_ADR || (seg == SEG_DAT && write));
    dq_oe  = drive ? lane_mask : 4'b0000;
    dq_out = drive ? lane_bits : 4'b0000;
  end

  assign rx_load = launch_evt && last_beat && !nxt_has && (seg == SEG_DAT) && !write;
  assign rx_word = rx_to_word(rx, frm.ndat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; seg <= SEG_OPC; cnt <= '0;
      beats <= '0; tx <= '0; rx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          if (frm.valid) begin
            state <= ST_SETUP; cnt <= setup_m1; seg <= SEG_OPC;
            tx <= {frm.opc, 32'h0}; beats <= BEAT_W'(8); rx <= '0;
          end else begin
            state <= ST_GAP; cnt <= idle_m1;
          end
        end
        ST_SETUP: if (cnt == '0) begin state <= ST_LOW; cnt <= half_m1; end
                  else cnt <= cnt - 1'b1;
        ST_LOW: if (cnt == '0) begin
          state <= ST_HIGH; cnt <= half_m1;
          if (seg == SEG_DAT && !write) begin
            unique case (cur_ll)
              2'd0:    rx <= {rx[WORD_W-2:0], dq_in[1]};
              2'd1:    rx <= {rx[WORD_W-3:0], dq_in[1:0]};
              default: rx <= {rx[WORD_W-5:0], dq_in};
            endcase
          end
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt == '0) begin
          if (!last_beat) begin
            state <= ST_LOW; cnt <= half_m1; beats <= beats - 1'b1;
            unique case (cur_ll)
              2'd0:    tx <= tx << 1;
              2'd1:    tx <= tx << 2;
              default: tx <= tx << 4;
            endcase
          end else if (nxt_has) begin
            state <= ST_LOW; cnt <= half_m1; seg <= nxt_seg;
            tx <= nxt_tx; beats <= nxt_beats;
          end else begin
            state <= ST_HOLD; cnt <= hold_m1;
          end
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) begin state <= ST_GAP; cnt <= idle_m1; end
                 else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfl_cmd_engine.sv
`timescale 1ns/1ps
module sfl_cmd_engine import sfl_pkg::*; #(
  parameter int TCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              fl_cs_n,
  output logic              fl_sck,
  output logic [3:0]        fl_dq_out,
  output logic [3:0]        fl_dq_oe,
  input  logic [3:0]        fl_dq_in
);
  logic [WORD_W-1:0] acc_q, ext_q, adr_q, dat_q, tim_q, typ_q, rx_word;
  logic start_pulse, write_q, eng_busy, rx_load, sample_evt, launch_evt;
  frame_t frm;

  sfl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
    .busy(eng_busy), .rx_load(rx_load), .rx_word(rx_word),
    .start_pulse(start_pulse), .write_q(write_q),
    .acc_q(acc_q), .ext_q(ext_q), .adr_q(adr_q),
    .dat_q(dat_q), .tim_q(tim_q), .typ_q(typ_q)
  );

  sfl_frame_dec u_dec (
    .code(acc_q[11:8]), .acc_opc(acc_q[7:0]), .multi_en(acc_q[24]),
    .width_sel(acc_q[31:30]), .size_sel(typ_q[10:9]), .ext_en(ext_q[31]),
    .ext_opc(ext_q[7:0]), .ext_adr_m1(ext_q[23:21]), .ext_dmy_m1(ext_q[29:24]),
    .ext_dat_m1(ext_q[20:8]), .frm(frm)
  );

  sfl_shifter #(.TCNT_W(TCNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .write(write_q), .frm(frm),
    .addr(adr_q), .wdata(dat_q), .div_sel(tim_q[26:24]),
    .setup_cyc(tim_q[23:16]), .hold_cyc(tim_q[15:8]), .idle_cyc(tim_q[7:0]),
    .dq_in(fl_dq_in), .cs_n(fl_cs_n), .sck(fl_sck), .dq_out(fl_dq_out),
    .dq_oe(fl_dq_oe), .busy(eng_busy), .rx_load(rx_load), .rx_word(rx_word),
    .sample_evt(sample_evt), .launch_evt(launch_evt)
  );
endmodule

// File: rtl/sfl_cmd_engine_chk.sv
`timescale 1ns/1ps
module sfl_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fl_cs_n,
  input logic        fl_sck,
  input logic [3:0]  fl_dq_out,
  input logic [3:0]  fl_dq_oe,
  input logic        busy,
  input logic        rx_load,
  input logic        sample_evt,
  input logic [31:0] acc_q,
  input logic [31:0] ext_q,
  input logic [31:0] adr_q,
  input logic [31:0] tim_q
);
  p_sck_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);
  p_lines_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> (fl_dq_oe == 4'b0000));
  p_select_means_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> busy);
  p_no_launch_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_sck) |-> $stable(fl_dq_out));
  p_sample_then_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> fl_sck);
  p_lane_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_dq_oe == 4'b0000) || (fl_dq_oe == 4'b0001) ||
    (fl_dq_oe == 4'b0011) || (fl_dq_oe == 4'b1111));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(acc_q) && $stable(ext_q) &&
                               $stable(adr_q) && $stable(tim_q)));
  p_read_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> busy);
endmodule

bind sfl_cmd_engine sfl_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fl_cs_n(fl_cs_n), .fl_sck(fl_sck),
  .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .busy(eng_busy),
  .rx_load(rx_load), .sample_evt(sample_evt), .acc_q(acc_q),
  .ext_q(ext_q), .adr_q(adr_q), .tim_q(tim_q)
);

// File: tb/test_sfl_cmd_engine.sv
`timescale 1ns/1ps
module test_sfl_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_waddr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [2:0]  reg_raddr = 3'd0;
  logic [31:0] reg_rdata;
  logic        fl_cs_n, fl_sck;
  logic [3:0]  fl_dq_out, fl_dq_oe;
  logic [3:0]  fl_dq_in = 4'd0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       cs_n;
    logic       sck;
    logic [3:0] oe;
    logic [3:0] dq;
    logic [3:0] din;
  } cyc_t;
  cyc_t exp_q[$];

  // bench-side copies of what it wrote
  logic [31:0] m_acc, m_ext, m_adr, m_dat, m_tim, m_typ;

  sfl_cmd_engine i_sfl_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .fl_cs_n(fl_cs_n), .fl_sck(fl_sck), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_waddr = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (idx)
      3'd1: m_acc = val; 3'd2: m_ext = val; 3'd3: m_adr = val;
      3'd4: m_dat = val; 3'd5: m_tim = val; 3'd6: m_typ = val;
      default: ;
    endcase
  endtask

  task automatic read_chk(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    reg_raddr = idx;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
    reg_raddr = 3'd0;
  endtask

  task automatic push(input logic cs, input logic ck, input logic [3:0] oe,
                      input logic [3:0] dq, input logic [3:0] din, input int n);
    cyc_t c;
    c.cs_n = cs; c.sck = ck; c.oe = oe; c.dq = dq; c.din = din;
    for (int i = 0; i < n; i++) exp_q.push_back(c);
  endtask

  task automatic beat(input int h, input logic [3:0] oe, input logic [3:0] dq, input logic [3:0] din);
    push(1'b0, 1'b0, oe, dq, din, h);
    push(1'b0, 1'b1, oe, dq, din, h);
  endtask

  function automatic int atleast1(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // expected line activity for one launch, built from the requirements
  task automatic plan(input bit wr, input logic [31:0] rd_word);
    int code, na, nd, nb, lanes, h;
    bit ok;
    logic [7:0] opc, byt;
    logic [3:0] mask, fld;
    exp_q.delete();
    code = int'(m_acc[11:8]);
    ok = 0; na = 0; nd = 0; nb = 0; lanes = 1; opc = 8'h00;
    h = int'(m_tim[26:24]) + 1;
    if (code == 0) begin ok = 1; opc = m_acc[7:0]; end
    else if (code == 5) begin ok = 1; opc = m_acc[7:0]; na = (m_typ[10:9] == 2'd2) ? 4 : 3; end
    else if (code == 15 && m_ext[31]) begin
      ok = 1; opc = m_ext[7:0];
      na = int'(m_ext[23:21]) + 1; if (na > 5) na = 5;
      nd = int'(m_ext[29:24]) + 1;
      nb = int'(m_ext[20:8]) + 1; if (nb > 4) nb = 4;
      if (m_acc[24] && m_acc[31:30] == 2'd1) lanes = 2;
      if (m_acc[24] && m_acc[31:30] == 2'd2) lanes = 4;
    end
    if (!ok) begin
      push(1'b1, 1'b0, 4'h0, 4'h0, 4'h0, atleast1(m_tim[7:0]));
      return;
    end
    push(1'b0, 1'b0, 4'b0001, {3'b0, opc[7]}, 4'h0, atleast1(m_tim[23:16]));
    for (int b = 7; b >= 0; b--) beat(h, 4'b0001, {3'b0, opc[b]}, 4'h0);
    for (int k = na - 1; k >= 0; k--) begin
      byt = (k == 4) ? 8'h00 : m_adr[8*k +: 8];
      for (int b = 7; b >= 0; b--) beat(h, 4'b0001, {3'b0, byt[b]}, 4'h0);
    end
    for (int k = 0; k < nd; k++) beat(h, 4'h0, 4'h0, 4'h0);
    mask = (lanes == 1) ? 4'b0001 : (lanes == 2) ? 4'b0011 : 4'b1111;
    for (int k = 0; k < nb; k++) begin
      byt = wr ? m_dat[8*k +: 8] : rd_word[8*k +: 8];
      for (int j = 8 - lanes; j >= 0; j -= lanes) begin
        fld = 4'((byt >> j) & ((1 << lanes) - 1));
        if (wr) beat(h, mask, fld, 4'h0);
        else    beat(h, 4'h0, 4'h0, (lanes == 1) ? {2'b00, fld[0], 1'b0} : fld);
      end
    end
    push(1'b0, 1'b0, 4'h0, 4'h0, 4'h0, atleast1(m_tim[15:8]));
    push(1'b1, 1'b0, 4'h0, 4'h0, 4'h0, atleast1(m_tim[7:0]));
  endtask

  // launch, then compare every system cycle against the plan
  task automatic run(input string tag, input logic [31:0] launch, input logic [31:0] rd_word, input bit poke);
    plan(launch[9], rd_word);
    reg_raddr = 3'd0;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_waddr = 3'd0; reg_wdata = launch;
    @(negedge clk);
    reg_wr_en = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (poke && k == 1) begin reg_wr_en = 1'b1; reg_waddr = 3'd1; reg_wdata = 32'hFFFF_FFFF; end
      if (poke && k == 2) begin reg_waddr = 3'd5; reg_wdata = 32'h0000_0000; end
      if (poke && k == 3) begin reg_waddr = 3'd0; reg_wdata = 32'h0000_0202; end
      if (poke && k == 4) reg_wr_en = 1'b0;
      check(tag, 64'({fl_cs_n, fl_sck, fl_dq_oe, fl_dq_out, reg_rdata[1]}),
            64'({exp_q[k].cs_n, exp_q[k].sck, exp_q[k].oe, exp_q[k].dq, 1'b1}));
      fl_dq_in = exp_q[k].din;
      @(negedge clk);
    end
    fl_dq_in = 4'h0;
    check({tag, " R2 done"}, 64'({fl_cs_n, reg_rdata[1]}), 64'({1'b1, 1'b0}));
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_acc = 0; m_ext = 0; m_adr = 0; m_dat = 0; m_tim = 0; m_typ = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", 64'({fl_cs_n, fl_sck, fl_dq_oe}), 64'({1'b1, 1'b0, 4'h0}));
    for (int i = 0; i < 7; i++) read_chk("R1 reg", 3'(i), 32'h0);

    // R3 R10 R12: opcode only, all timing fields zero (minimum one)
    write_reg(3'd5, 32'h0000_0000);
    write_reg(3'd1, 32'h0000_00A5);
    run("R3 R10 R12 opcode-only", 32'h0000_0002, 32'h0, 1'b0);

    // R4 R10: three-byte address, slower clock and longer timing
    write_reg(3'd5, 32'h0203_0204);
    write_reg(3'd6, 32'h0000_0000);
    write_reg(3'd3, 32'h0012_3456);
    write_reg(3'd1, 32'h0000_0520);
    run("R4 R10 addr3", 32'h0000_0002, 32'h0, 1'b0);

    // R4: four-byte address
    write_reg(3'd5, 32'h0101_0101);
    write_reg(3'd6, 32'h0000_0400);
    write_reg(3'd3, 32'hDEAD_BEEF);
    run("R4 addr4", 32'h0000_0002, 32'h0, 1'b0);

    // R5 R8: extended single-line read of four bytes
    write_reg(3'd5, 32'h0001_0101);
    write_reg(3'd1, 32'h0000_0F00);
    write_reg(3'd2, 32'h8740_030B);
    write_reg(3'd3, 32'h00AB_CDEF);
    run("R5 R8 read1", 32'h0000_0002, 32'hCAFE_F00D, 1'b0);
    read_chk("R8 read word", 3'd4, 32'hCAFE_F00D);

    // R7 R9: dual-line write
    write_reg(3'd5, 32'h0100_0000);
    write_reg(3'd1, 32'h4100_0F00);
    write_reg(3'd2, 32'h8040_03A2);
    write_reg(3'd4, 32'h1122_3344);
    run("R7 R9 write2", 32'h0000_0202, 32'h0, 1'b0);
    read_chk("R7 data kept", 3'd4, 32'h1122_3344);

    // R8 R9 R11 R2: quad read of two bytes with writes made while busy
    write_reg(3'd5, 32'h0001_0102);
    write_reg(3'd1, 32'h8100_0F00);
    write_reg(3'd2, 32'h8100_016B);
    run("R8 R9 R11 read4", 32'h0000_0002, 32'h7766_5A3C, 1'b1);
    read_chk("R8 partial word", 3'd4, 32'h0000_5A3C);
    read_chk("R11 access kept", 3'd1, 32'h8100_0F00);
    read_chk("R11 timing kept", 3'd5, 32'h0001_0102);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 no relaunch", 64'({fl_cs_n, reg_rdata[1]}), 64'({1'b1, 1'b0}));
    end

    // R5: address count capped at five, data count capped at four, write
    write_reg(3'd5, 32'h0000_0000);
    write_reg(3'd1, 32'h0000_0F00);
    write_reg(3'd2, 32'h80C0_6402);
    write_reg(3'd3, 32'h89AB_CDEF);
    write_reg(3'd4, 32'hA1B2_C3D4);
    run("R5 R7 caps", 32'h0000_0202, 32'h0, 1'b0);

    // R6: extended code with enable clear, then an unused code
    write_reg(3'd5, 32'h0000_0003);
    write_reg(3'd2, 32'h0040_030B);
    run("R6 ext off", 32'h0000_0002, 32'h0, 1'b0);
    write_reg(3'd1, 32'h0000_0300);
    run("R6 bad code", 32'h0000_0002, 32'h0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule